// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Cell

This block is a single output cell of a small programmable logic array. An AND array outside the block hands it a set of product terms. The cell ORs those terms together and applies a programmable polarity. It then drives its pad either straight from that sum or through a D register. It also picks where the pad's output enable comes from, and which signal it returns to the array as feedback. Two global architecture bits are shared by every cell of the array. Two per-cell bits pick the cell's variant within the global architecture and its output polarity.

The register has a synchronous active-low reset that stands for the power-up clear. It also has a synchronous preload, so that test sequencing can force any register state, legal or not. The register stores the inverse of the pad level. A cleared register therefore shows a high pad in every polarity.

A cell sitting in the middle of the pad row has no feedback path of its own in the always-on architecture. It is always an output there. This variant is chosen at elaboration with a parameter.

Top module: `sop_macrocell`

## Requirements
- R1: The architecture is decoded from {arch_hi, arch_lo}: 2'b01 registered, 2'b11 shared-enable combinational, 2'b10 always-on combinational, 2'b00 parked. In registered architecture with cell_alt=0, the register captures the OR of all terms_i bits on each rising clk edge. pin_o then equals that OR when cell_pol=1 and its inverse when cell_pol=0. pin_o changes only after the edge.
- R2: In the registered cell (registered architecture, cell_alt=0), pin_oe equals grp_oe and fb_o equals pin_o.
- R3: In registered architecture with cell_alt=1, and in shared-enable architecture, pin_o is the OR of terms_i[NUM_TERMS-1:1], passed through when cell_pol=1 and inverted when cell_pol=0. pin_oe equals terms_i[0], and terms_i[0] takes no part in the sum.
- R4: In always-on architecture with cell_alt=0, pin_o is the OR of all terms_i bits, under the same polarity rule, and pin_oe is 1.
- R5: In always-on architecture with cell_alt=1, a non-centre cell is an input only and pin_oe is 0.
- R6: fb_o equals nbr_pad in always-on architecture (non-centre cell). It equals pad_in in shared-enable architecture and in the registered-architecture cell with cell_alt=1.
- R7: A cell built with IS_CENTER=1, in always-on architecture, ignores cell_alt. It keeps pin_oe at 1 and pin_o from the full sum, and fb_o is 0.
- R8: A rising edge with rst_n=0 clears the register, so the registered cell's pin_o reads 1 for either cell_pol value.
- R9: A rising edge with rst_n=1 and preload_en=1 loads preload_val into the register in place of the sum. The registered cell's pin_o then reads the inverse of preload_val.
- R10: When rst_n=0 and preload_en=1 at the same edge, the reset wins and pin_o reads 1.
- R11: In parked architecture, pin_oe is 0, pin_o is 0 and fb_o equals pad_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared register clock |
| rst_n | input | 1 | Synchronous active-low clear of the register |
| arch_hi | input | 1 | Global architecture bit, upper |
| arch_lo | input | 1 | Global architecture bit, lower |
| cell_alt | input | 1 | Per-cell variant select |
| cell_pol | input | 1 | Per-cell polarity, 1 = active high |
| terms_i | input | NUM_TERMS | Product terms from the AND array |
| grp_oe | input | 1 | Shared output enable for registered cells |
| pad_in | input | 1 | Level seen on this cell's own pad |
| nbr_pad | input | 1 | Level seen on the neighbouring pad |
| preload_en | input | 1 | Force preload_val into the register at the edge |
| preload_val | input | 1 | Value forced into the register |
| pin_o | output | 1 | Pad data |
| pin_oe | output | 1 | Pad drive enable |
| fb_o | output | 1 | Feedback into the AND array |

## Verification
Reset, preload and the normal data capture all act on the same register at the same edge. So the interesting collisions are preload against capture, and reset against preload. The bench holds a term pattern whose captured value is the opposite of preload_val while preload_en is high. It then raises preload_en while rst_n is low. Each case is judged at pin_o just after the edge, against the level that the winning source alone predicts.

// File: rtl/mc_pkg.sv
// Shared types for the sum-of-products output cell.
// Assumes: the decoder yields one configuration word that the router consumes.
package mc_pkg;

    // Global architecture, indexed by {arch_hi, arch_lo}
    typedef enum logic [1:0] {
        ARCH_PARK   = 2'b00,
        ARCH_REG    = 2'b01,
        ARCH_SIMPLE = 2'b10,
        ARCH_CPLX   = 2'b11
    } arch_e;

    typedef enum logic [1:0] {OE_OFF, OE_ON, OE_GROUP, OE_TERM} oe_src_e;
    typedef enum logic [1:0] {FB_NONE, FB_REG, FB_PAD, FB_NBR} fb_src_e;
    typedef enum logic [1:0] {PIN_ZERO, PIN_REG, PIN_DATA, PIN_ALL} pin_src_e;

    typedef struct packed {
        oe_src_e  oe;
        fb_src_e  fb;
        pin_src_e pin;
    } cell_cfg_t;

endpackage

// File: rtl/mc_decode.sv
// Mode decoder: turns the global and per-cell bits into source selections.
// Assumes: IS_CENTER marks a cell with no feedback path in always-on mode.
module mc_decode
    import mc_pkg::*;
#(
    parameter bit IS_CENTER = 1'b0
) (
    input  logic      arch_hi,
    input  logic      arch_lo,
    input  logic      cell_alt,
    output cell_cfg_t cfg
);

    arch_e     arch;
    cell_cfg_t simple_cfg;

    assign arch = arch_e'({arch_hi, arch_lo});

    // Always-on variant depends on whether the cell sits in the middle
    generate
        if (IS_CENTER) begin : g_center
            assign simple_cfg = '{oe: OE_ON, fb: FB_NONE, pin: PIN_ALL};
        end else begin : g_edge
            assign simple_cfg = cell_alt ? '{oe: OE_OFF, fb: FB_NBR, pin: PIN_ALL}
                                         : '{oe: OE_ON,  fb: FB_NBR, pin: PIN_ALL};
        end
    endgenerate

    // Select the configuration for the decoded architecture
    always_comb begin
        case (arch)
            ARCH_REG:    cfg = cell_alt ? '{oe: OE_TERM,  fb: FB_PAD, pin: PIN_DATA}
                                        : '{oe: OE_GROUP, fb: FB_REG, pin: PIN_REG};
            ARCH_CPLX:   cfg = '{oe: OE_TERM, fb: FB_PAD, pin: PIN_DATA};
            ARCH_SIMPLE: cfg = simple_cfg;
            default:     cfg = '{oe: OE_OFF, fb: FB_PAD, pin: PIN_ZERO};
        endcase
    end

endmodule

// File: rtl/mc_sum.sv
// OR plane and polarity: full sum, data-only sum, and register next state.
// Assumes: term 0 doubles as enable term; register holds the inverse pad level.
module mc_sum #(
    parameter int NUM_TERMS = 8
) (
    input  logic [NUM_TERMS-1:0] terms,
    input  logic                 pol,
    output logic                 comb_all,
    output logic                 comb_data,
    output logic                 reg_d
);

    localparam int DATA_LO = 1;

    logic or_all;
    logic or_data;

    // Reduce the product terms
    assign or_all  = |terms;
    assign or_data = |terms[NUM_TERMS-1:DATA_LO];

    // Apply polarity, pol=1 passes the sum
    assign comb_all  = or_all  ^ ~pol;
    assign comb_data = or_data ^ ~pol;

    // Register keeps inverted pad level
    assign reg_d = ~comb_all;

endmodule

// File: rtl/mc_state.sv
// Cell register with synchronous clear and synchronous preload.
// Assumes: clear has priority over preload, preload over data.
module mc_state (
    input  logic clk,
    input  logic rst_n,
    input  logic preload_en,
    input  logic preload_val,
    input  logic d,
    output logic q
);

    // Capture clear, preload or data at each edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (preload_en) begin
            q <= preload_val;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/mc_route.sv
// Output, enable and feedback multiplexers driven by the decoded configuration.
// Assumes: enable term is terms[0]; a registered pad shows the inverted register.
module mc_route
    import mc_pkg::*;
(
    input  cell_cfg_t cfg,
    input  logic      q,
    input  logic      comb_all,
    input  logic      comb_data,
    input  logic      en_term,
    input  logic      grp_oe,
    input  logic      pad_in,
    input  logic      nbr_pad,
    output logic      pin_o,
    output logic      pin_oe,
    output logic      fb_o
);

    // Pad data source
    always_comb begin
        case (cfg.pin)
            PIN_REG:  pin_o = ~q;
            PIN_DATA: pin_o = comb_data;
            PIN_ALL:  pin_o = comb_all;
            default:  pin_o = 1'b0;
        endcase
    end

    // Pad enable source
    always_comb begin
        case (cfg.oe)
            OE_ON:    pin_oe = 1'b1;
            OE_GROUP: pin_oe = grp_oe;
            OE_TERM:  pin_oe = en_term;
            default:  pin_oe = 1'b0;
        endcase
    end

    // Feedback source
    always_comb begin
        case (cfg.fb)
            FB_REG:  fb_o = ~q;
            FB_PAD:  fb_o = pad_in;
            FB_NBR:  fb_o = nbr_pad;
            default: fb_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sop_macrocell.sv
// Configurable output cell: OR plane, polarity, register, enable and feedback select.
// Assumes: NUM_TERMS >= 2; mode bits are quasi-static; reset is synchronous active low.
module sop_macrocell
    import mc_pkg::*;
#(
    parameter int NUM_TERMS = 8,
    parameter bit IS_CENTER = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arch_hi,
    input  logic                 arch_lo,
    input  logic                 cell_alt,
    input  logic                 cell_pol,
    input  logic [NUM_TERMS-1:0] terms_i,
    input  logic                 grp_oe,
    input  logic                 pad_in,
    input  logic                 nbr_pad,
    input  logic                 preload_en,
    input  logic                 preload_val,
    output logic                 pin_o,
    output logic                 pin_oe,
    output logic                 fb_o
);

    cell_cfg_t cfg;
    logic      comb_all;
    logic      comb_data;
    logic      reg_d;
    logic      q;

    mc_decode #(.IS_CENTER(IS_CENTER)) u_dec (
        .arch_hi  (arch_hi),
        .arch_lo  (arch_lo),
        .cell_alt (cell_alt),
        .cfg      (cfg)
    );

    mc_sum #(.NUM_TERMS(NUM_TERMS)) u_sum (
        .terms     (terms_i),
        .pol       (cell_pol),
        .comb_all  (comb_all),
        .comb_data (comb_data),
        .reg_d     (reg_d)
    );

    mc_state u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .preload_en  (preload_en),
        .preload_val (preload_val),
        .d           (reg_d),
        .q           (q)
    );

    mc_route u_route (
        .cfg       (cfg),
        .q         (q),
        .comb_all  (comb_all),
        .comb_data (comb_data),
        .en_term   (terms_i[0]),
        .grp_oe    (grp_oe),
        .pad_in    (pad_in),
        .nbr_pad   (nbr_pad),
        .pin_o     (pin_o),
        .pin_oe    (pin_oe),
        .fb_o      (fb_o)
    );

endmodule

// File: rtl/mc_checker.sv
// Port-level properties of the output cell, bound to every instance.
// Assumes: inputs settle away from the rising edge.
module mc_checker #(
    parameter int NUM_TERMS = 8,
    parameter bit IS_CENTER = 1'b0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 arch_hi,
    input logic                 arch_lo,
    input logic                 cell_alt,
    input logic                 cell_pol,
    input logic [NUM_TERMS-1:0] terms_i,
    input logic                 grp_oe,
    input logic                 preload_en,
    input logic                 preload_val,
    input logic                 pin_o,
    input logic                 pin_oe,
    input logic                 fb_o
);

    logic reg_cell;
    logic simple_mode;
    logic term_oe_mode;
    logic park_mode;
    logic armed = 1'b0;
    logic rst_seen = 1'b0;

    assign reg_cell     = !arch_hi && arch_lo && !cell_alt;
    assign simple_mode  = arch_hi && !arch_lo;
    assign term_oe_mode = arch_lo && (arch_hi || cell_alt);
    assign park_mode    = !arch_hi && !arch_lo;

    // Remember whether the last edge saw reset
    always @(posedge clk) begin
        armed    <= 1'b1;
        rst_seen <= !rst_n;
    end

    AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_cell && !preload_en) |=> (!reg_cell || pin_o == $past(cell_pol ? |terms_i : !(|terms_i))))
        else $error("register capture mismatch"); // R1

    AST_REG_GROUP_OE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_cell |-> (pin_oe == grp_oe && fb_o == pin_o))
        else $error("registered cell enable or feedback wrong"); // R2

    AST_TERM_OE: assert property (@(posedge clk) disable iff (!rst_n)
        term_oe_mode |-> pin_oe == terms_i[0])
        else $error("enable term not routed"); // R3

    AST_PRELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        preload_en |=> (!reg_cell || pin_o == !$past(preload_val)))
        else $error("preload not loaded"); // R9

    AST_PARK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        park_mode |-> (!pin_oe && !pin_o))
        else $error("parked cell active"); // R11

    generate
        if (IS_CENTER) begin : g_center
            AST_CENTER_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
                simple_mode |-> (pin_oe && !fb_o))
                else $error("centre cell not a plain output"); // R7
        end else begin : g_edge
            AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
                (simple_mode && cell_alt) |-> !pin_oe)
                else $error("input cell drives pad"); // R5
        end
    endgenerate

    // Between edges, a cleared register shows a high pad
    always @(negedge clk) begin
        if (armed && rst_seen && reg_cell) begin
            AST_RESET_HIGH: assert (pin_o) else $error("pad low after clear"); // R8
        end
    end

endmodule

bind sop_macrocell mc_checker #(.NUM_TERMS(NUM_TERMS), .IS_CENTER(IS_CENTER)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arch_hi     (arch_hi),
    .arch_lo     (arch_lo),
    .cell_alt    (cell_alt),
    .cell_pol    (cell_pol),
    .terms_i     (terms_i),
    .grp_oe      (grp_oe),
    .preload_en  (preload_en),
    .preload_val (preload_val),
    .pin_o       (pin_o),
    .pin_oe      (pin_oe),
    .fb_o        (fb_o)
);

// File: tb/sim_sop_macrocell.sv
// Bench: combinational vector table, then directed register, reset and centre tests.
module sim_sop_macrocell;

    localparam int NT   = 8;
    localparam int NVEC = 12;

    // {arch_hi, arch_lo, cell_alt, cell_pol, terms, pad_in, nbr_pad, exp_pin, exp_oe, exp_fb}
    localparam logic [16:0] VEC [NVEC] = '{
        {4'b1101, 8'h03, 2'b01, 3'b110},
        {4'b1100, 8'h02, 2'b10, 3'b001},
        {4'b1111, 8'h01, 2'b00, 3'b010},
        {4'b1100, 8'h01, 2'b10, 3'b111},
        {4'b0111, 8'h81, 2'b00, 3'b110},
        {4'b0110, 8'h80, 2'b10, 3'b001},
        {4'b1001, 8'h01, 2'b10, 3'b110},
        {4'b1000, 8'h00, 2'b01, 3'b111},
        {4'b1001, 8'h00, 2'b01, 3'b011},
        {4'b1011, 8'hff, 2'b00, 3'b100},
        {4'b0001, 8'hff, 2'b10, 3'b001},
        {4'b0010, 8'h00, 2'b00, 3'b000}
    };

    logic clk = 1'b0;
    logic rst_n, arch_hi, arch_lo, cell_alt, cell_pol;
    logic [NT-1:0] terms_i;
    logic grp_oe, pad_in, nbr_pad, preload_en, preload_val;
    logic p0, oe0, fb0, p1, oe1, fb1;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    sop_macrocell #(.NUM_TERMS(NT), .IS_CENTER(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .arch_hi(arch_hi), .arch_lo(arch_lo),
        .cell_alt(cell_alt), .cell_pol(cell_pol), .terms_i(terms_i), .grp_oe(grp_oe),
        .pad_in(pad_in), .nbr_pad(nbr_pad), .preload_en(preload_en),
        .preload_val(preload_val), .pin_o(p0), .pin_oe(oe0), .fb_o(fb0)
    );

    sop_macrocell #(.NUM_TERMS(NT), .IS_CENTER(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .arch_hi(arch_hi), .arch_lo(arch_lo),
        .cell_alt(cell_alt), .cell_pol(cell_pol), .terms_i(terms_i), .grp_oe(grp_oe),
        .pad_in(pad_in), .nbr_pad(nbr_pad), .preload_en(preload_en),
        .preload_val(preload_val), .pin_o(p1), .pin_oe(oe1), .fb_o(fb1)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_mode(input logic hi, input logic lo, input logic alt, input logic pol);
        arch_hi  = hi;
        arch_lo  = lo;
        cell_alt = alt;
        cell_pol = pol;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; preload_en = 1'b0; preload_val = 1'b0;
        terms_i = '0; grp_oe = 1'b1; pad_in = 1'b0; nbr_pad = 1'b0;
        set_mode(1'b0, 1'b1, 1'b0, 1'b0);
        tick();
        tick();

        // Reset state of the registered cell
        check("R8", "pad after clear, pol 0", p0, 1'b1);
        check("R2", "group enable", oe0, 1'b1);
        cell_pol = 1'b1;
        #1;
        check("R8", "pad after clear, pol 1", p0, 1'b1);
        rst_n = 1'b1;

        // Combinational table
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tick();
            {arch_hi, arch_lo, cell_alt, cell_pol} = VEC[i][16:13];
            terms_i = VEC[i][12:5];
            {pad_in, nbr_pad} = VEC[i][4:3];
            #1;
            if (!arch_hi && !arch_lo)      tag = "R11";
            else if (arch_hi && !arch_lo)  tag = cell_alt ? "R5" : "R4";
            else                           tag = "R3";
            check(tag, "pad data", p0, VEC[i][2]);
            check(tag, "pad enable", oe0, VEC[i][1]);
            check((!arch_hi && !arch_lo) ? "R11" : "R6", "feedback", fb0, VEC[i][0]);
        end

        // Registered capture
        tick();
        set_mode(1'b0, 1'b1, 1'b0, 1'b1);
        terms_i = 8'h10; grp_oe = 1'b1;
        tick();
        check("R1", "capture active high", p0, 1'b1);
        check("R2", "feedback equals pad", fb0, 1'b1);
        cell_pol = 1'b0;
        #1;
        check("R1", "pad holds until edge", p0, 1'b1);
        tick();
        check("R1", "capture active low", p0, 1'b0);
        check("R2", "feedback equals pad low", fb0, 1'b0);
        terms_i = 8'h00; grp_oe = 1'b0;
        tick();
        check("R1", "empty sum active low", p0, 1'b1);
        check("R2", "group enable off", oe0, 1'b0);

        // Preload against a capture of the opposite value
        grp_oe = 1'b1; cell_pol = 1'b1; terms_i = 8'hff;
        preload_en = 1'b1; preload_val = 1'b1;
        tick();
        check("R9", "preload overrides sum", p0, 1'b0);
        preload_val = 1'b0;
        tick();
        check("R9", "preload low", p0, 1'b1);
        preload_en = 1'b0; cell_pol = 1'b0;
        tick();
        check("R1", "capture resumes", p0, 1'b0);

        // Reset and preload at the same edge
        preload_en = 1'b1; preload_val = 1'b1; rst_n = 1'b0;
        tick();
        check("R10", "reset beats preload", p0, 1'b1);
        rst_n = 1'b1; preload_en = 1'b0;

        // Centre cell in always-on architecture
        set_mode(1'b1, 1'b0, 1'b1, 1'b1);
        terms_i = 8'h01; nbr_pad = 1'b1; pad_in = 1'b0;
        #1;
        check("R7", "centre enable with alt set", oe1, 1'b1);
        check("R7", "centre feedback", fb1, 1'b0);
        check("R7", "centre pad data", p1, 1'b1);
        check("R5", "edge cell is input", oe0, 1'b0);
        check("R6", "edge cell neighbour feedback", fb0, 1'b1);
        cell_alt = 1'b0; cell_pol = 1'b0;
        #1;
        check("R7", "centre pad data active low", p1, 1'b0);
        check("R7", "centre enable alt clear", oe1, 1'b1);

        // Centre cell outside always-on architecture uses its pad
        set_mode(1'b1, 1'b1, 1'b0, 1'b1);
        pad_in = 1'b1;
        #1;
        check("R6", "centre pad feedback in shared-enable", fb1, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule